// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects up to eight interrupt request lines and presents a single interrupt signal to a processor. A request is captured when its line rises and stays pending while the line is held high. Pending requests pass through a mask register and are compared against the levels already in service. The processor answers the interrupt with two acknowledge pulses. On the first pulse the winning request moves from pending into service. On the second pulse the block places an 8-bit vector on its data output. The vector is built from a programmed base and the 3-bit level number.

A level leaves service only when the processor issues an end-of-interrupt command. That command is either non-specific, which retires the most urgent level in service, or specific, which names the level to retire. A parameter lists the levels that have a downstream controller attached. When one of those levels is acknowledged, the block marks the vector cycle as not its own and keeps its data output at zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request is captured on the clock edge at which its line is first seen high after being low. The pending bit clears at any edge where the line is low. A line that stays high after being acknowledged does not request again.
- R2: `int_req` is high only when some pending, unmasked level is more urgent than every level in service. Equal and less urgent levels are held off. `int_req` follows a request rise by two clock edges, and follows a mask write or an end-of-interrupt command by two edges.
- R3: Level 0 is the most urgent and level 7 the least urgent. The lowest-numbered eligible level wins arbitration.
- R4: On the first acknowledge pulse, the winning level's pending bit clears and its in-service bit sets. `int_req` stays low from that pulse until one edge after the second pulse.
- R5: One edge after the second pulse is sampled, `vec_out` holds `{base, level}`. Here `base` is the last `base_data` written into bits 7:3, and the level is in bits 2:0. `vec_vld` is high at the same time and clears at the first edge with `ack` low.
- R6: If nothing is eligible at the first pulse, the vector carries level 7 and no in-service bit is set.
- R7: A non-specific end-of-interrupt clears the most urgent in-service level.
- R8: A specific end-of-interrupt clears the in-service bit named by `eoi_lvl`.
- R9: For a level flagged in `CAS_MASK`, the second pulse gives `vec_own`=0 and `vec_out`=0 with `vec_vld`=1. For any other level, `vec_own`=1.
- R10: After reset, `int_req`, `vec_vld`, `vec_own` and `vec_out` are all zero. The mask and the in-service state are cleared.
- R11: In-service bits never clear on their own after an acknowledge. Only an end-of-interrupt command removes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, bit n is level n |
| mask_wr | input | 1 | Strobe to load the mask register |
| mask_data | input | 8 | Mask value, 1 blocks the level |
| base_wr | input | 1 | Strobe to load the vector base |
| base_data | input | 5 | Upper five vector bits |
| eoi_ns | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_sp | input | 1 | Specific end-of-interrupt strobe |
| eoi_lvl | input | 3 | Level retired by a specific end-of-interrupt |
| ack | input | 1 | Acknowledge level from the processor, high during a pulse |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector data |
| vec_vld | output | 1 | Vector data valid |
| vec_own | output | 1 | This controller supplies the vector |

## Verification
After a request line rises, the pending bit sets on the next edge and `int_req` responds on the edge after that. The bench therefore waits three falling edges before it samples. Mask writes and end-of-interrupt strobes change state on one edge, and the interrupt output reflects them on the next. The vector appears one edge after the second pulse is first sampled high, and the bench reads it at the following falling edge, while `ack` is still high. The bench checks `int_req` between the two pulses, and checks it again two edges after the second pulse ends, once the block has re-evaluated its inputs.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_WAIT2 = 1'b1
  } ack_ph_t;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] take,
  output logic [N-1:0] irr
);
  logic [N-1:0] irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq_in;
      irr   <= (irr & irq_in & ~take) | (irq_in & ~irq_q);
    end
  end

  // a low line never leaves its pending bit set
  assert_drop_clears_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr & ~$past(irq_in)) == '0));
endmodule

// File: rtl/pic_svc.sv
module pic_svc #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic [W-1:0] set_lvl,
  input  logic         eoi_ns,
  input  logic         eoi_sp,
  input  logic [W-1:0] eoi_lvl,
  output logic [N-1:0] isr,
  output logic         top_found,
  output logic [W-1:0] top_idx
);
  logic [N-1:0] clr_m;
  logic [N-1:0] set_m;

  pic_prio_enc #(.N(N)) u_top (
    .vec   (isr),
    .found (top_found),
    .idx   (top_idx)
  );

  always_comb begin
    clr_m = '0;
    if (eoi_ns && top_found) clr_m = clr_m | (N'(1) << top_idx);
    if (eoi_sp)              clr_m = clr_m | (N'(1) << eoi_lvl);
    set_m = set_en ? (N'(1) << set_lvl) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= (isr & ~clr_m) | set_m;
  end

  assert_eoi_sp_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi_sp && !(set_en && set_lvl == eoi_lvl)) |=> !isr[$past(eoi_lvl)]);

  assert_eoi_ns_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi_ns && top_found && !set_en) |=> !isr[$past(top_idx)]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLVL = 8,
  parameter int VW = 8,
  parameter logic [NLVL-1:0] CAS_MASK = '0,
  localparam int LW = $clog2(NLVL),
  localparam int BW = VW - LW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] irq_in,
  input  logic            mask_wr,
  input  logic [NLVL-1:0] mask_data,
  input  logic            base_wr,
  input  logic [BW-1:0]   base_data,
  input  logic            eoi_ns,
  input  logic            eoi_sp,
  input  logic [LW-1:0]   eoi_lvl,
  input  logic            ack,
  output logic            int_req,
  output logic [VW-1:0]   vec_out,
  output logic            vec_vld,
  output logic            vec_own
);
  import pic_pkg::*;

  ack_ph_t         phase;
  logic            ack_q;
  logic [NLVL-1:0] mask_q;
  logic [BW-1:0]   base_q;
  logic [LW-1:0]   sel_lvl;
  logic [NLVL-1:0] irr;
  logic [NLVL-1:0] isr;
  logic [NLVL-1:0] take;
  logic            win_found;
  logic [LW-1:0]   win_idx;
  logic            svc_found;
  logic [LW-1:0]   svc_idx;
  logic            any_ok;
  logic            ack_rise;
  logic            edge1;
  logic            edge2;
  logic            own_now;

  assign ack_rise = ack && !ack_q;
  assign edge1    = ack_rise && (phase == PH_IDLE);
  assign edge2    = ack_rise && (phase == PH_WAIT2);
  assign any_ok   = win_found && (!svc_found || (win_idx < svc_idx));
  assign take     = (edge1 && any_ok) ? (NLVL'(1) << win_idx) : '0;
  assign own_now  = !CAS_MASK[sel_lvl];

  pic_req_latch #(.N(NLVL)) u_req (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .take   (take),
    .irr    (irr)
  );

  pic_prio_enc #(.N(NLVL)) u_win (
    .vec   (irr & ~mask_q),
    .found (win_found),
    .idx   (win_idx)
  );

  pic_svc #(.N(NLVL)) u_svc (
    .clk       (clk),
    .rst       (rst),
    .set_en    (edge1 && any_ok),
    .set_lvl   (win_idx),
    .eoi_ns    (eoi_ns),
    .eoi_sp    (eoi_sp),
    .eoi_lvl   (eoi_lvl),
    .isr       (isr),
    .top_found (svc_found),
    .top_idx   (svc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      phase   <= PH_IDLE;
      mask_q  <= '0;
      base_q  <= '0;
      sel_lvl <= '0;
      int_req <= 1'b0;
      vec_out <= '0;
      vec_vld <= 1'b0;
      vec_own <= 1'b0;
    end else begin
      ack_q <= ack;
      if (mask_wr) mask_q <= mask_data;
      if (base_wr) base_q <= base_data;
      int_req <= (phase == PH_IDLE) && !ack_rise && any_ok;
      if (edge1) begin
        phase   <= PH_WAIT2;
        sel_lvl <= any_ok ? win_idx : '1;
      end else if (edge2) begin
        phase   <= PH_IDLE;
        vec_vld <= 1'b1;
        vec_own <= own_now;
        vec_out <= own_now ? {base_q, sel_lvl} : '0;
      end else if (!ack) begin
        vec_vld <= 1'b0;
        vec_own <= 1'b0;
        vec_out <= '0;
      end
    end
  end

  assert_no_req_mid_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT2) |-> !int_req);

  assert_one_new_svc_R4: assert property (@(posedge clk) disable iff (rst)
    edge1 |=> ($countones(isr & ~$past(isr)) <= 1));

  assert_vec_after_second_R5: assert property (@(posedge clk) disable iff (rst)
    edge2 |=> vec_vld);

  assert_spurious_lvl_R6: assert property (@(posedge clk) disable iff (rst)
    (edge1 && !any_ok) |=> (sel_lvl == '1) && ((isr & ~$past(isr)) == '0));

  assert_own_implies_vld_R9: assert property (@(posedge clk) disable iff (rst)
    vec_own |-> vec_vld);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_data = '0;
  logic       base_wr = 1'b0;
  logic [4:0] base_data = '0;
  logic       eoi_ns = 1'b0;
  logic       eoi_sp = 1'b0;
  logic [2:0] eoi_lvl = '0;
  logic       ack = 1'b0;
  logic       int_req;
  logic [7:0] vec_out;
  logic       vec_vld;
  logic       vec_own;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] BASE = 5'b10101;

  // fields: irq[19:12] mask[11:4] expect_int[3] level[2:0]
  localparam logic [19:0] TBL [7] = '{
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'h80, 8'h00, 1'b1, 3'd7},
    {8'h28, 8'h00, 1'b1, 3'd3},
    {8'h28, 8'h08, 1'b1, 3'd5},
    {8'hFF, 8'hFF, 1'b0, 3'd0},
    {8'hF0, 8'h00, 1'b1, 3'd4},
    {8'h06, 8'h04, 1'b1, 3'd1}
  };

  always #4 clk = ~clk;

  prio_irq_ctrl #(.CAS_MASK(8'h04)) u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_wr(mask_wr), .mask_data(mask_data),
    .base_wr(base_wr), .base_data(base_data), .eoi_ns(eoi_ns), .eoi_sp(eoi_sp),
    .eoi_lvl(eoi_lvl), .ack(ack), .int_req(int_req), .vec_out(vec_out),
    .vec_vld(vec_vld), .vec_own(vec_own)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_mask(input logic [7:0] m);
    @(negedge clk) mask_wr = 1'b1; mask_data = m;
    @(negedge clk) mask_wr = 1'b0;
    idle(2);
  endtask

  task automatic send_ns();
    @(negedge clk) eoi_ns = 1'b1;
    @(negedge clk) eoi_ns = 1'b0;
    idle(2);
  endtask

  task automatic send_sp(input logic [2:0] l);
    @(negedge clk) eoi_sp = 1'b1; eoi_lvl = l;
    @(negedge clk) eoi_sp = 1'b0;
    idle(2);
  endtask

  task automatic do_ack(output logic [7:0] v, output logic o, output logic vl, output logic mid);
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0; mid = int_req;
    @(negedge clk) ack = 1'b1;
    @(negedge clk) v = vec_out; o = vec_own; vl = vec_vld; ack = 1'b0;
    idle(2);
  endtask

  initial begin
    logic [7:0] v;
    logic o, vl, mid;
    idle(3);
    @(negedge clk) rst = 1'b0;
    check("R10 int_req", int_req, 0);
    check("R10 vec_vld", vec_vld, 0);
    check("R10 vec_own", vec_own, 0);
    check("R10 vec_out", vec_out, 0);
    @(negedge clk) base_wr = 1'b1; base_data = BASE;
    @(negedge clk) base_wr = 1'b0;

    // table walk: R2 R3 R5 under several patterns
    for (int e = 0; e < 7; e++) begin
      set_mask(TBL[e][11:4]);
      @(negedge clk) irq_in = TBL[e][19:12];
      idle(3);
      check("R2 R3 table int_req", int_req, TBL[e][3]);
      if (TBL[e][3]) begin
        do_ack(v, o, vl, mid);
        check("R4 table mid-ack int_req", mid, 0);
        check("R5 table vector", v, {BASE, TBL[e][2:0]});
        check("R5 table valid", vl, 1);
      end
      @(negedge clk) irq_in = '0;
      set_mask(8'h00);
      send_ns();
    end

    // nesting: R11 R2 R3 R7 R8
    @(negedge clk) irq_in = 8'h20;
    idle(3);
    do_ack(v, o, vl, mid);
    check("R5 level5 vector", v, {BASE, 3'd5});
    @(negedge clk) irq_in = 8'h60;
    idle(3);
    check("R11 R2 lower level held off", int_req, 0);
    @(negedge clk) irq_in = 8'h40;
    @(negedge clk) irq_in = 8'h60;
    idle(3);
    check("R2 equal level held off", int_req, 0);
    @(negedge clk) irq_in = 8'h68;
    idle(3);
    check("R3 higher level passes", int_req, 1);
    do_ack(v, o, vl, mid);
    check("R3 nested vector", v, {BASE, 3'd3});
    send_ns();
    check("R7 level5 still blocks", int_req, 0);
    send_sp(3'd5);
    check("R8 R7 level5 released", int_req, 1);
    do_ack(v, o, vl, mid);
    check("R8 re-served level5", v, {BASE, 3'd5});
    send_sp(3'd5);
    check("R8 level6 now eligible", int_req, 1);
    do_ack(v, o, vl, mid);
    check("R3 level6 vector", v, {BASE, 3'd6});
    send_ns();
    @(negedge clk) irq_in = '0;
    idle(2);

    // held line does not request again
    @(negedge clk) irq_in = 8'h01;
    idle(3);
    do_ack(v, o, vl, mid);
    send_ns();
    idle(2);
    check("R1 held line no re-request", int_req, 0);
    @(negedge clk) irq_in = '0;
    idle(2);

    // vanished request
    @(negedge clk) irq_in = 8'h10;
    idle(3);
    check("R2 level4 raised", int_req, 1);
    @(negedge clk) irq_in = '0;
    do_ack(v, o, vl, mid);
    check("R6 spurious vector", v, {BASE, 3'd7});
    check("R6 spurious own", o, 1);
    @(negedge clk) irq_in = 8'h80;
    idle(3);
    check("R6 nothing put in service", int_req, 1);
    do_ack(v, o, vl, mid);
    send_ns();
    @(negedge clk) irq_in = '0;
    idle(2);

    // cascade level
    @(negedge clk) irq_in = 8'h04;
    idle(3);
    do_ack(v, o, vl, mid);
    check("R9 cascade own", o, 0);
    check("R9 cascade data", v, 0);
    check("R9 cascade valid", vl, 1);
    check("R5 valid clears after ack low", vec_vld, 0);
    send_sp(3'd2);
    @(negedge clk) irq_in = '0;
    idle(2);

    // mask holds a request without losing it
    set_mask(8'h02);
    @(negedge clk) irq_in = 8'h02;
    idle(3);
    check("R2 masked no int", int_req, 0);
    set_mask(8'h00);
    check("R2 unmask raises int", int_req, 1);
    do_ack(v, o, vl, mid);
    check("R9 own level1", o, 1);
    check("R5 level1 vector", v, {BASE, 3'd1});
    send_ns();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule